// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table kept in ordinary memory. A requester hands over a virtual address and an access kind (read, write or execute). The walker reads one entry from the top-level table, whose base address is held in a register that software loads. If that entry is present, the walker reads one entry from the second-level table it points to. It then answers with either a physical address and a no-cache flag, or a fault with a two-bit cause.

On a successful data access the walker keeps the usage bookkeeping of the final entry up to date. It sets the referenced bit, and on a write it also sets the modified bit. It stores the entry back through the same single-transaction memory port, and does so only when one of those bits actually changes. Only one walk is in flight at a time. A new request is taken only after the previous answer has been consumed.

Top module: `pt_walker`

## Requirements
- R1: Virtual address bits [31:22] select the top-level slot and bits [21:12] the second-level slot. Each entry is one 4-byte word, so a slot sits at {table_frame, 12'h000} + index*4. The top-level table frame is base[31:12]. The second-level table frame is bits [31:12] of the top-level entry.
- R2: A top-level entry whose bit 0 (present) is 0 gives a fault with cause 2'b01. No second-level read is made.
- R3: A second-level entry whose bit 0 is 0 gives a fault with cause 2'b10. No write-back is made.
- R4: The access code selects the permission bit of the second-level entry: 2'b00 read uses bit 1, 2'b01 write uses bit 2, and 2'b10 or 2'b11 execute uses bit 3. When that bit is clear the result is a fault with cause 2'b11. The present check comes first.
- R5: On success the walker reports rsp_fault=0 and rsp_cause=2'b00. The physical address is {entry[31:12], vaddr[11:0]}, and rsp_nocache copies entry bit 6.
- R6: A successful read or write sets entry bit 4 (referenced). A successful write also sets bit 5 (modified). The updated word is written back once to the same slot, and only when it differs from the word read. Execute accesses and faults never write.
- R7: The memory port carries one transaction at a time. A request stays valid with stable address, direction and data until mem_req_ready. Read data is taken on mem_rdata_valid, one or more cycles after the read handshake.
- R8: req_ready is high only while no walk or answer is pending. An answer stays valid and stable until rsp_ready.
- R9: base_we loads the base register from base_wdata. Bits [11:0] are ignored. A load during a walk affects only requests accepted after it.
- R10: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0, and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load strobe for the table base register |
| base_wdata | input | 32 | New table base (low 12 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 1x execute |
| rsp_valid | output | 1 | Answer valid |
| rsp_ready | input | 1 | Answer consumed |
| rsp_fault | output | 1 | Answer is a fault |
| rsp_cause | output | 2 | 00 none, 01 top absent, 10 leaf absent, 11 permission |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_nocache | output | 1 | No-cache flag of the final entry |
| mem_req_valid | output | 1 | Memory transaction valid |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry word read from memory |

## Verification
The assertions check the following on every cycle:
- memory requests and answers stay stable while stalled;
- entry addresses are word aligned;
- every write-back carries present and referenced bits;
- an absent top-level entry ends the walk with cause 01;
- the fault flag agrees with the cause code;
- a successful answer keeps the page offset.

The bench scenarios show the rest:
- which slot is read from which base;
- that faults and execute accesses leave memory untouched;
- that an already-marked entry is not rewritten;
- that a base load in the middle of a walk is deferred to the next request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int AW       = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int SLOT_SH  = 2;
  localparam int FRAME_W  = AW - OFF_W;

  localparam int B_PRESENT = 0;
  localparam int B_RD      = 1;
  localparam int B_WR      = 2;
  localparam int B_EX      = 3;
  localparam int B_REF     = 4;
  localparam int B_MOD     = 5;
  localparam int B_NC      = 6;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_ROOT = 2'b01,
    CAUSE_LEAF = 2'b10,
    CAUSE_PROT = 2'b11
  } cause_e;

  function automatic logic [IDX_W-1:0] top_index(input logic [AW-1:0] va);
    return va[AW-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] low_index(input logic [AW-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] tbl,
                                              input logic [IDX_W-1:0] idx);
    logic [AW-1:0] off;
    off = '0;
    off[SLOT_SH +: IDX_W] = idx;
    return {tbl[AW-1:OFF_W], {OFF_W{1'b0}}} + off;
  endfunction

  function automatic logic allowed(input logic [AW-1:0] pte, input logic [1:0] acc);
    case (acc)
      2'b00:   return pte[B_RD];
      2'b01:   return pte[B_WR];
      default: return pte[B_EX];
    endcase
  endfunction

  function automatic logic [AW-1:0] marked(input logic [AW-1:0] pte, input logic [1:0] acc);
    logic [AW-1:0] r;
    r = pte;
    if (!acc[1])       r[B_REF] = 1'b1;
    if (acc == 2'b01)  r[B_MOD] = 1'b1;
    return r;
  endfunction

  function automatic logic [AW-1:0] join_pa(input logic [AW-1:0] pte, input logic [AW-1:0] va);
    return {pte[AW-1:OFF_W], va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg import pt_walker_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  base_q <= '0;
    else if (we) base_q <= wdata;
  end

  assign base_o = base_q;
endmodule

// File: rtl/pt_leaf_eval.sv
module pt_leaf_eval import pt_walker_pkg::*; (
  input  logic [AW-1:0] pte,
  input  logic [AW-1:0] va,
  input  logic [1:0]    acc,
  output logic          absent,
  output logic          denied,
  output logic [AW-1:0] paddr,
  output logic          nocache,
  output logic [AW-1:0] new_pte,
  output logic          need_wb
);
  always_comb begin
    absent  = !pte[B_PRESENT];
    denied  = !allowed(pte, acc);
    paddr   = join_pa(pte, va);
    nocache = pte[B_NC];
    new_pte = marked(pte, acc);
    need_wb = (new_pte != pte);
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl import pt_walker_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_acc,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [1:0]    rsp_cause,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_nocache,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rdata_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] va_o,
  output logic [1:0]    acc_o,
  input  logic          leaf_absent,
  input  logic          leaf_denied,
  input  logic [AW-1:0] leaf_paddr,
  input  logic          leaf_nocache,
  input  logic [AW-1:0] leaf_new,
  input  logic          leaf_need_wb
);
  typedef enum logic [2:0] {
    S_IDLE, S_TOP_REQ, S_TOP_WAIT, S_LOW_REQ, S_LOW_WAIT, S_WB, S_RESP
  } st_e;

  st_e           st;
  logic [AW-1:0] va_q, maddr_q, mwdata_q, pa_q;
  logic [1:0]    acc_q;
  logic          fault_q, nc_q;
  cause_e        cause_q;

  logic req_fire, mem_fire, top_data, low_data;
  assign req_fire = req_valid && req_ready;
  assign mem_fire = mem_req_valid && mem_req_ready;
  assign top_data = (st == S_TOP_WAIT) && mem_rdata_valid;
  assign low_data = (st == S_LOW_WAIT) && mem_rdata_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      maddr_q  <= '0;
      mwdata_q <= '0;
      pa_q     <= '0;
      fault_q  <= 1'b0;
      nc_q     <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_fire) begin
          va_q    <= req_vaddr;
          acc_q   <= req_acc;
          maddr_q <= slot_addr(base_i, top_index(req_vaddr));
          st      <= S_TOP_REQ;
        end
        S_TOP_REQ: if (mem_fire) st <= S_TOP_WAIT;
        S_TOP_WAIT: if (top_data) begin
          if (!mem_rdata[B_PRESENT]) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_ROOT;
            pa_q    <= '0;
            nc_q    <= 1'b0;
            st      <= S_RESP;
          end else begin
            maddr_q <= slot_addr(mem_rdata, low_index(va_q));
            st      <= S_LOW_REQ;
          end
        end
        S_LOW_REQ: if (mem_fire) st <= S_LOW_WAIT;
        S_LOW_WAIT: if (low_data) begin
          if (leaf_absent || leaf_denied) begin
            fault_q <= 1'b1;
            cause_q <= leaf_absent ? CAUSE_LEAF : CAUSE_PROT;
            pa_q    <= '0;
            nc_q    <= 1'b0;
            st      <= S_RESP;
          end else begin
            fault_q  <= 1'b0;
            cause_q  <= CAUSE_NONE;
            pa_q     <= leaf_paddr;
            nc_q     <= leaf_nocache;
            mwdata_q <= leaf_new;
            st       <= leaf_need_wb ? S_WB : S_RESP;
          end
        end
        S_WB:   if (mem_fire) st <= S_RESP;
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = pa_q;
  assign rsp_nocache   = nc_q;
  assign mem_req_valid = (st == S_TOP_REQ) || (st == S_LOW_REQ) || (st == S_WB);
  assign mem_req_write = (st == S_WB);
  assign mem_req_addr  = maddr_q;
  assign mem_req_wdata = mwdata_q;
  assign va_o          = va_q;
  assign acc_o         = acc_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_cause) && $stable(rsp_nocache)); // R8
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[SLOT_SH-1:0] == '0); // R1
  AST_TOP_ABSENT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    top_data && !mem_rdata[B_PRESENT] |=> rsp_valid && rsp_cause == CAUSE_ROOT); // R2
  AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[B_REF] && mem_req_wdata[B_PRESENT]); // R6
  AST_CAUSE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault == (rsp_cause != CAUSE_NONE)); // R5
endmodule

// File: rtl/pt_walker.sv
module pt_walker import pt_walker_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [31:0]   base_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_vaddr,
  input  logic [1:0]    req_acc,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [1:0]    rsp_cause,
  output logic [31:0]   rsp_paddr,
  output logic          rsp_nocache,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [31:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rdata_valid,
  input  logic [31:0]   mem_rdata
);
  logic [AW-1:0] base_w, va_w, lf_paddr, lf_new;
  logic [1:0]    acc_w;
  logic          lf_absent, lf_denied, lf_nc, lf_wb;

  pt_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .we(base_we), .wdata(base_wdata), .base_o(base_w)
  );

  pt_leaf_eval u_eval (
    .pte(mem_rdata), .va(va_w), .acc(acc_w),
    .absent(lf_absent), .denied(lf_denied), .paddr(lf_paddr),
    .nocache(lf_nc), .new_pte(lf_new), .need_wb(lf_wb)
  );

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .base_i(base_w),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata(mem_rdata), .va_o(va_w), .acc_o(acc_w),
    .leaf_absent(lf_absent), .leaf_denied(lf_denied), .leaf_paddr(lf_paddr),
    .leaf_nocache(lf_nc), .leaf_new(lf_new), .leaf_need_wb(lf_wb)
  );

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == va_w[OFF_W-1:0]); // R5
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, base_we, req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault, rsp_nocache;
  logic [31:0] base_wdata, req_vaddr, rsp_paddr, mem_req_addr, mem_req_wdata, mem_rdata;
  logic [1:0]  req_acc, rsp_cause;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rdata_valid;

  pt_walker uut (.*);

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] rdq[$];
  logic [63:0] wbq[$];
  logic [31:0] mbase = 32'h0;
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int r, input int l, input int off);
    return {r[9:0], l[9:0], off[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder and per-cycle protocol checks
  initial begin : responder
    bit rd_pend;
    int lat;
    logic [31:0] pend_addr;
    rd_pend = 0; lat = 0; pend_addr = 0;
    mem_req_ready = 0; mem_rdata_valid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_rdata_valid = 0;
      if (rst_n) begin
        chk("R8 no accept while answer pending", {63'h0, req_ready && rsp_valid}, 64'h0);
        chk("R7 single outstanding", {63'h0, rd_pend && mem_req_valid}, 64'h0);
      end
      if (rd_pend) begin
        mem_req_ready = 0;
        if (lat == 0) begin
          mem_rdata_valid = 1;
          mem_rdata = rd(pend_addr);
          rd_pend = 0;
        end else lat--;
      end else begin
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_valid && mem_req_ready && rst_n) begin
          if (mem_req_write) begin
            if (wbq.size() == 0) chk("R6 unexpected write-back", {mem_req_addr, mem_req_wdata}, 64'h0);
            else chk("R6 write-back word", {mem_req_addr, mem_req_wdata}, wbq.pop_front());
            pmem[mem_req_addr] = mem_req_wdata;
          end else begin
            if (rdq.size() == 0) chk("R2 unexpected read", {32'h0, mem_req_addr}, 64'h0);
            else chk("R1 entry address", {32'h0, mem_req_addr}, {32'h0, rdq.pop_front()});
            rd_pend = 1; pend_addr = mem_req_addr; lat = $urandom % 3;
          end
        end
      end
    end
  end

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1; base_wdata = b;
    @(negedge clk);
    base_we = 0;
    mbase = {b[31:12], 12'h000};
  endtask

  task automatic xlate(input string tag, input logic [31:0] va, input logic [1:0] acc,
                       input bit chg, input logic [31:0] nb);
    logic [31:0] ta, te, la, le, ne, epa;
    logic [1:0] ecause;
    logic enc;
    bit ok;
    ta = {mbase[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    te = rd(ta);
    rdq.push_back(ta);
    epa = 0; enc = 0; ecause = 2'b00;
    if (!te[0]) ecause = 2'b01;
    else begin
      la = {te[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      le = rd(la);
      rdq.push_back(la);
      ok = (acc == 2'b00) ? le[1] : (acc == 2'b01) ? le[2] : le[3];
      if (!le[0]) ecause = 2'b10;
      else if (!ok) ecause = 2'b11;
      else begin
        epa = {le[31:12], va[11:0]};
        enc = le[6];
        ne = le;
        if (acc == 2'b00 || acc == 2'b01) ne = ne | 32'h10;
        if (acc == 2'b01) ne = ne | 32'h20;
        if (ne != le) wbq.push_back({la, ne});
      end
    end
    @(negedge clk);
    rsp_ready = 0;
    req_vaddr = va; req_acc = acc; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (chg) begin
      base_we = 1; base_wdata = nb;
      @(negedge clk);
      base_we = 0;
      mbase = {nb[31:12], 12'h000};
    end
    forever begin
      rsp_ready = ($urandom % 2) != 0;
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
    end
    chk({tag, " fault/cause"}, {61'h0, rsp_fault, rsp_cause}, {61'h0, ecause != 2'b00, ecause});
    chk({tag, " paddr/nocache"}, {31'h0, rsp_nocache, rsp_paddr}, {31'h0, enc, epa});
    chk({tag, " memory traffic complete"}, {32'h0, rdq.size(), wbq.size()} , 64'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; base_we = 0; base_wdata = 0; req_valid = 0; req_vaddr = 0; req_acc = 0; rsp_ready = 0;
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0001_0008] = 32'h0002_0000;
    pmem[32'h0002_000C] = 32'hABCD_E007;
    pmem[32'h0002_0010] = 32'h1111_1013;
    pmem[32'h0002_0014] = 32'h2222_2006;
    pmem[32'h0002_0018] = 32'h3333_3049;
    pmem[32'h0002_001C] = 32'h4444_403F;
    pmem[32'h0003_0004] = 32'h0004_0001;
    pmem[32'h0004_000C] = 32'h1234_5003;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset state", {61'h0, req_ready, rsp_valid, mem_req_valid}, {61'h0, 3'b100});
    set_base(32'h0001_0FFF);   // R9 low bits ignored
    xlate("R5 R6 read marks referenced",     mkva(1, 3, 12'h123), 2'b00, 0, 0);
    xlate("R6 write marks modified",         mkva(1, 3, 12'hFFF), 2'b01, 0, 0);
    xlate("R6 write on marked entry no wb",  mkva(1, 3, 12'h000), 2'b01, 0, 0);
    xlate("R6 read already referenced",      mkva(1, 4, 12'h456), 2'b00, 0, 0);
    xlate("R4 write denied",                 mkva(1, 4, 12'h456), 2'b01, 0, 0);
    xlate("R2 top entry absent",             mkva(2, 3, 12'h001), 2'b00, 0, 0);
    xlate("R3 leaf entry absent",            mkva(1, 5, 12'h002), 2'b01, 0, 0);
    xlate("R4 R5 execute with nocache",      mkva(1, 6, 12'hA5A), 2'b10, 0, 0);
    xlate("R4 execute code 11",              mkva(1, 6, 12'h5A5), 2'b11, 0, 0);
    xlate("R4 read denied on exec page",     mkva(1, 6, 12'h010), 2'b00, 0, 0);
    xlate("R6 full-rights write no wb",      mkva(1, 7, 12'h7FC), 2'b01, 0, 0);
    xlate("R9 base load mid-walk deferred",  mkva(1, 3, 12'h321), 2'b10, 1, 32'h0003_0ABC);
    xlate("R9 new base used next",           mkva(1, 3, 12'h321), 2'b00, 0, 0);
    for (int i = 0; i < 20; i++)
      xlate("R7 R1 stall mix", mkva(1, 3 + (i % 5) * 0, i * 37), 2'(i % 3), 0, 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule